// File: doc/BRIEF.md
# I2C Target Controller with Software Clock Stretching

This block is the target (slave) side of an I2C bus. It is clocked by the system clock and oversamples the SCL and SDA lines. It recognises START and STOP conditions. It compares the first byte after a START with its own 7-bit address, or with a two-byte 10-bit address. It then receives bytes written by the bus controller or sends bytes to it. Both lines are driven open-drain: an output high means pull the line low.

Software reaches the block through a small word-wide register port. Through it software sets the own address, loads the next byte to send and reads the last byte received. It also enables an interrupt for each of three events and clears sticky event flags. Two bits of the control word act on the bus. One replaces the next acknowledge the target would give with a NACK, once. The other holds SCL low, so that software gains time between bytes.

Top module: `i2ct_target`

## Requirements
- R1: After reset the control word (offset 0) and the low address byte (offset 2) read 0, scl_oe, sda_oe and irq are 0.
- R2: Only control bits 10..6 and bit 0 are stored (bits 15..11 and 5..1 read 0), and offset 1 keeps only bits 9..8 and 6..0.
- R3: A STOP (SDA rising while SCL is high) sets status bit 2 (offset 3); with control bit 8 set, irq rises.
- R4: With control bit 0 clear, a first byte whose upper seven bits equal offset 1 bits 6..0 is ACKed; any other address gets no ACK for the rest of the transfer and stores nothing.
- R5: With control bit 0 set, a first byte 11110 followed by offset 1 bits 9..8 and a 0 is ACKed, and then a second byte equal to offset 2 is ACKed; a different second byte is NACKed.
- R6: In 10-bit mode, a header 11110 + bits 9..8 + 1 after a repeated START is ACKed only if the full 10-bit address matched earlier in the same transfer (before any STOP), and it starts a transmit.
- R7: Each data byte written by the bus controller is ACKed, can be read at offset 5, and sets status bit 0.
- R8: A read transfer sends the byte at offset 4 MSB first and reloads offset 4 after each controller ACK. A controller NACK ends the send. The acknowledge slot of each sent byte sets status bit 1. SDA changes only while SCL is low.
- R9: irq is the OR of status bits 0, 1, 2 masked by control bits 9, 10, 8. Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R10: Control bit 7 turns the next acknowledge the target would give into a NACK. The bit then clears itself, and the following bytes are ACKed again. A byte NACKed this way is still stored.
- R11: Setting control bit 6 while SCL is low makes scl_oe high within one cycle and keeps SCL low until the bit is cleared.
- R12: Setting control bit 6 while SCL is high leaves scl_oe low until SCL next falls, then holds SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the stretch hold rules on every cycle: the hold is immediate when SCL is low, it waits when SCL is high, and it releases on clear. They also check that SDA moves only while the synchronized SCL is low, that the one-shot NACK bit clears itself once used, and that an enabled receive event raises irq. Address matching in both widths, the repeated-START rule of 10-bit reads, MSB-first ordering of sent bytes and the ACK/NACK seen by the bus controller need whole transfers. Those are shown only by the bench scenarios, which play the bus controller against a wired-AND bus.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SHORT_W   = 7;
  localparam int unsigned LONG_HI_W = 2;
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned NEV       = 3;

  // event flag positions in the status word
  localparam int unsigned EV_RX   = 0;
  localparam int unsigned EV_TX   = 1;
  localparam int unsigned EV_STOP = 2;

  // control word bit positions
  localparam int unsigned CB_MODE    = 0;
  localparam int unsigned CB_STRETCH = 6;
  localparam int unsigned CB_NACK    = 7;
  localparam int unsigned CB_STOP_IE = 8;
  localparam int unsigned CB_RX_IE   = 9;
  localparam int unsigned CB_TX_IE   = 10;

  localparam logic [15:0] CTRL_MASK = 16'h07C1;
  localparam logic [15:0] SELF_MASK = 16'h037F;

  // register offsets
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_SELF = 1;
  localparam int unsigned OFS_LOWB = 2;
  localparam int unsigned OFS_STAT = 3;
  localparam int unsigned OFS_TXB  = 4;
  localparam int unsigned OFS_RXB  = 5;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR1, LS_ADDR2, LS_RX, LS_ACK, LS_TX, LS_TXACK, LS_WAIT
  } link_st_t;

  // 7-bit address compare on a received header byte
  function automatic logic short_hit(input logic [BYTE_W-1:0] b,
                                     input logic [SHORT_W-1:0] a);
    return b[BYTE_W-1:1] == a;
  endfunction

  // 10-bit header prefix compare (direction bit ignored)
  function automatic logic long_hdr_hit(input logic [BYTE_W-1:0] b,
                                        input logic [LONG_HI_W-1:0] hi);
    return (b[7:3] == 5'b11110) && (b[2:1] == hi);
  endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '1;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[LAST];
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = ~scl_d & scl_s;
  assign scl_fall = scl_d & ~scl_s;
  assign start_ev = scl_d & scl_s & sda_d & ~sda_s;
  assign stop_ev  = scl_d & scl_s & ~sda_d & sda_s;
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int unsigned RA_W   = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [RA_W-1:0]      addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 rx_done,
  input  logic                 tx_done,
  input  logic                 stop_ev,
  input  logic                 nack_used,
  input  logic [BYTE_W-1:0]    rx_byte,
  output logic                 ten_mode,
  output logic                 stretch_en,
  output logic                 nack_once,
  output logic                 rx_ie,
  output logic [SHORT_W-1:0]   short_addr,
  output logic [LONG_HI_W-1:0] long_hi,
  output logic [BYTE_W-1:0]    long_lo,
  output logic [BYTE_W-1:0]    tx_byte,
  output logic                 irq
);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] SMASK = DATA_W'(SELF_MASK);

  logic [DATA_W-1:0] ctrl_q, self_q;
  logic [BYTE_W-1:0] lowb_q, txb_q;
  logic [NEV-1:0]    stat_q, ev_set, ie_vec;
  logic              wr_ctrl, wr_self, wr_lowb, wr_stat, wr_txb;

  assign wr_ctrl = wr && (addr == RA_W'(OFS_CTRL));
  assign wr_self = wr && (addr == RA_W'(OFS_SELF));
  assign wr_lowb = wr && (addr == RA_W'(OFS_LOWB));
  assign wr_stat = wr && (addr == RA_W'(OFS_STAT));
  assign wr_txb  = wr && (addr == RA_W'(OFS_TXB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= wdata & CMASK;
    end else if (nack_used) begin
      ctrl_q[CB_NACK] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      self_q <= '0;
      lowb_q <= '0;
      txb_q  <= '0;
    end else begin
      if (wr_self) self_q <= wdata & SMASK;
      if (wr_lowb) lowb_q <= wdata[BYTE_W-1:0];
      if (wr_txb)  txb_q  <= wdata[BYTE_W-1:0];
    end
  end

  assign ev_set[EV_RX]   = rx_done;
  assign ev_set[EV_TX]   = tx_done;
  assign ev_set[EV_STOP] = stop_ev;

  assign ie_vec[EV_RX]   = ctrl_q[CB_RX_IE];
  assign ie_vec[EV_TX]   = ctrl_q[CB_TX_IE];
  assign ie_vec[EV_STOP] = ctrl_q[CB_STOP_IE];

  // one sticky flag per event; a new event wins over a clear
  for (genvar g = 0; g < NEV; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    stat_q[g] <= 1'b0;
      else if (ev_set[g])            stat_q[g] <= 1'b1;
      else if (wr_stat && wdata[g])  stat_q[g] <= 1'b0;
    end
  end

  assign irq = |(stat_q & ie_vec);

  always_comb begin
    rdata = '0;
    case (addr)
      RA_W'(OFS_CTRL): rdata = ctrl_q;
      RA_W'(OFS_SELF): rdata = self_q;
      RA_W'(OFS_LOWB): rdata = DATA_W'(lowb_q);
      RA_W'(OFS_STAT): rdata = DATA_W'(stat_q);
      RA_W'(OFS_TXB):  rdata = DATA_W'(txb_q);
      RA_W'(OFS_RXB):  rdata = DATA_W'(rx_byte);
      default:         rdata = '0;
    endcase
  end

  assign ten_mode   = ctrl_q[CB_MODE];
  assign stretch_en = ctrl_q[CB_STRETCH];
  assign nack_once  = ctrl_q[CB_NACK];
  assign rx_ie      = ctrl_q[CB_RX_IE];
  assign short_addr = self_q[SHORT_W-1:0];
  assign long_hi    = self_q[8 +: LONG_HI_W];
  assign long_lo    = lowb_q;
  assign tx_byte    = txb_q;
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_ev,
  input  logic                 stop_ev,
  input  logic                 sda_s,
  input  logic                 ten_mode,
  input  logic                 nack_once,
  input  logic [SHORT_W-1:0]   short_addr,
  input  logic [LONG_HI_W-1:0] long_hi,
  input  logic [BYTE_W-1:0]    long_lo,
  input  logic [BYTE_W-1:0]    tx_byte,
  output logic                 sda_drive,
  output logic                 rx_done,
  output logic [BYTE_W-1:0]    rx_byte,
  output logic                 tx_done,
  output logic                 nack_used
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  link_st_t          st, after;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, rx_next;
  logic              ack_val, ack_on, mack, long_hit;
  logic              want_ack, give_ack;
  link_st_t          next_st;

  assign rx_next  = {shreg[BYTE_W-2:0], sda_s};
  assign give_ack = want_ack & ~nack_once;

  // acknowledge decision for the byte completing at this rising edge
  always_comb begin
    want_ack = 1'b0;
    next_st  = LS_WAIT;
    case (st)
      LS_ADDR1: begin
        if (!ten_mode) begin
          want_ack = short_hit(rx_next, short_addr);
          next_st  = rx_next[0] ? LS_TX : LS_RX;
        end else if (long_hdr_hit(rx_next, long_hi)) begin
          want_ack = rx_next[0] ? long_hit : 1'b1;
          next_st  = rx_next[0] ? LS_TX : LS_ADDR2;
        end
      end
      LS_ADDR2: begin
        want_ack = (rx_next == long_lo);
        next_st  = LS_RX;
      end
      LS_RX: begin
        want_ack = 1'b1;
        next_st  = LS_RX;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LS_IDLE;
      after     <= LS_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      sda_drive <= 1'b0;
      ack_val   <= 1'b0;
      ack_on    <= 1'b0;
      mack      <= 1'b0;
      long_hit  <= 1'b0;
      rx_byte   <= '0;
      rx_done   <= 1'b0;
      tx_done   <= 1'b0;
      nack_used <= 1'b0;
    end else begin
      rx_done   <= 1'b0;
      tx_done   <= 1'b0;
      nack_used <= 1'b0;
      if (stop_ev) begin
        st        <= LS_IDLE;
        sda_drive <= 1'b0;
        long_hit  <= 1'b0;
      end else if (start_ev) begin
        st        <= LS_ADDR1;
        bitcnt    <= '0;
        sda_drive <= 1'b0;
      end else begin
        case (st)
          LS_ADDR1, LS_ADDR2, LS_RX: begin
            if (scl_rise) begin
              shreg  <= rx_next;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                st        <= LS_ACK;
                ack_on    <= 1'b0;
                ack_val   <= give_ack;
                after     <= give_ack ? next_st : LS_WAIT;
                nack_used <= want_ack & nack_once;
                if (st == LS_ADDR2 && give_ack) long_hit <= 1'b1;
                if (st == LS_RX) begin
                  rx_byte <= rx_next;
                  rx_done <= 1'b1;
                end
              end
            end
          end
          LS_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                ack_on    <= 1'b1;
                sda_drive <= ack_val;
              end else begin
                st     <= after;
                bitcnt <= '0;
                if (after == LS_TX) begin
                  sda_drive <= ~tx_byte[BYTE_W-1];
                  shreg     <= {tx_byte[BYTE_W-2:0], 1'b0};
                end else begin
                  sda_drive <= 1'b0;
                end
              end
            end
          end
          LS_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == ALL_BITS) begin
                st        <= LS_TXACK;
                sda_drive <= 1'b0;
              end else begin
                sda_drive <= ~shreg[BYTE_W-1];
                shreg     <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          LS_TXACK: begin
            if (scl_rise) begin
              mack    <= ~sda_s;
              tx_done <= 1'b1;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                st        <= LS_TX;
                sda_drive <= ~tx_byte[BYTE_W-1];
                shreg     <= {tx_byte[BYTE_W-2:0], 1'b0};
              end else begin
                st        <= LS_WAIT;
                sda_drive <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RA_W        = 3,
  parameter int unsigned DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic                 scl_s, sda_s;
  logic                 scl_rise, scl_fall, start_ev, stop_ev;
  logic                 ten_mode, stretch_en, nack_once, rx_ie;
  logic [SHORT_W-1:0]   short_addr;
  logic [LONG_HI_W-1:0] long_hi;
  logic [BYTE_W-1:0]    long_lo, tx_byte, rx_byte;
  logic                 sda_drive, rx_done, tx_done, nack_used;
  logic                 hold_q;

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2ct_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2ct_regs #(.RA_W(RA_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .rx_done(rx_done), .tx_done(tx_done), .stop_ev(stop_ev),
    .nack_used(nack_used), .rx_byte(rx_byte),
    .ten_mode(ten_mode), .stretch_en(stretch_en), .nack_once(nack_once),
    .rx_ie(rx_ie), .short_addr(short_addr), .long_hi(long_hi),
    .long_lo(long_lo), .tx_byte(tx_byte), .irq(irq)
  );

  i2ct_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
    .ten_mode(ten_mode), .nack_once(nack_once), .short_addr(short_addr),
    .long_hi(long_hi), .long_lo(long_lo), .tx_byte(tx_byte),
    .sda_drive(sda_drive), .rx_done(rx_done), .rx_byte(rx_byte),
    .tx_done(tx_done), .nack_used(nack_used)
  );

  // stretch: grab SCL as soon as it is seen low, keep it until disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= stretch_en & (hold_q | ~scl_s);
  end

  assign scl_oe = hold_q;
  assign sda_oe = sda_drive;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int unsigned RA_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_s,
  input logic            scl_oe,
  input logic            sda_oe,
  input logic            irq,
  input logic            stretch_en,
  input logic            nack_once,
  input logic            nack_used,
  input logic            rx_done,
  input logic            rx_ie,
  input logic            reg_wr,
  input logic [RA_W-1:0] reg_addr
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);

  AST_STRETCH_LOW_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_en && !scl_s) |=> scl_oe);                                  // R11
  AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !stretch_en |=> !scl_oe);                                            // R11
  AST_STRETCH_WAIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && scl_s) |=> !scl_oe);                                     // R12
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);                                        // R8
  AST_NACK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_used && !ctrl_wr) |=> !nack_once);                             // R10
  AST_RX_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ie && !ctrl_wr) |=> irq);                             // R9
endmodule

bind i2ct_target i2ct_checker #(.RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .stretch_en(stretch_en), .nack_once(nack_once),
  .nack_used(nack_used), .rx_done(rx_done), .rx_ie(rx_ie),
  .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int RA_W       = 3;
  localparam int DATA_W     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic scl_line, sda_line;
  logic reg_wr = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2ct_target #(.RA_W(RA_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard driver side and monitor side
  task automatic expect_byte(input string tag, input logic [7:0] v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        chk(tag_q.pop_front(), {24'd0, act_q.pop_front()}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    @(negedge clk);
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; wq();
    scl_up(); wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq();
    scl_up(); wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq();
    scl_up(); wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq();
    scl_up(); wq();
    b = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic rd_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  task automatic reg_write(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RA_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = RA_W'(a);
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic        ack;
    logic [7:0]  b;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    reg_read(0, d); chk("R1 ctrl", d, 16'h0000);
    reg_read(2, d); chk("R1 lowb", d, 16'h0000);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);

    // R2 stored bits
    reg_write(0, 16'hFFFF); reg_read(0, d); chk("R2 ctrl mask", d, 16'h07C1);
    reg_write(0, 16'h0000);
    reg_write(1, 16'hFFFF); reg_read(1, d); chk("R2 self mask", d, 16'h037F);
    reg_write(1, 16'h003A);
    reg_write(3, 16'h0007);

    // R4 R7 R9: 7-bit write with rx interrupt
    reg_write(0, 16'h0200);
    m_start();
    wr_byte(8'h74, ack); chk("R4 addr ack", ack, 1);
    wr_byte(8'h5C, ack); chk("R7 data ack", ack, 1);
    m_stop();
    expect_byte("R7 rxdata", 8'h5C);
    reg_read(5, d); act_q.push_back(d[7:0]);
    reg_read(3, d); chk("R7 rx flag", d[0], 1);
    chk("R9 irq on rx", irq, 1);
    reg_write(3, 16'h0001);
    chk("R9 irq cleared", irq, 0);
    reg_read(3, d); chk("R9 w1c only bit0", d, 16'h0004);
    reg_write(3, 16'h0004);

    // R4 address mismatch
    m_start();
    wr_byte(8'h40, ack); chk("R4 mismatch nack", ack, 0);
    wr_byte(8'h99, ack); chk("R4 ignored data", ack, 0);
    m_stop();
    reg_read(3, d); chk("R4 no rx flag", d[0], 0);
    reg_read(5, d); chk("R4 rxdata kept", d[7:0], 8'h5C);
    reg_write(3, 16'h0007);

    // R3 stop interrupt
    reg_write(0, 16'h0100);
    chk("R3 irq idle", irq, 0);
    m_start(); wr_byte(8'h40, ack); m_stop();
    chk("R3 irq on stop", irq, 1);
    reg_read(3, d); chk("R3 stop flag", d[2], 1);
    reg_write(3, 16'h0007);

    // R8 read transfer, MSB first, reload, tx interrupt
    reg_write(0, 16'h0400);
    reg_write(4, 16'h00A5);
    m_start();
    wr_byte(8'h75, ack); chk("R8 read addr ack", ack, 1);
    reg_write(4, 16'h003C);
    expect_byte("R8 first byte", 8'hA5);
    expect_byte("R8 reloaded byte", 8'h3C);
    rd_byte(b, 1'b1); act_q.push_back(b);
    rd_byte(b, 1'b0); act_q.push_back(b);
    chk("R8 sda released after nack", sda_oe, 0);
    m_stop();
    chk("R8 irq on tx", irq, 1);
    reg_read(3, d); chk("R8 tx flag", d[1], 1);
    reg_write(3, 16'h0007);

    // R10 one-shot nack override
    reg_write(0, 16'h0000);
    m_start();
    wr_byte(8'h74, ack); chk("R10 addr ack", ack, 1);
    reg_write(0, 16'h0080);
    wr_byte(8'h11, ack); chk("R10 forced nack", ack, 0);
    reg_read(0, d); chk("R10 self clear", d[7], 0);
    m_stop();
    expect_byte("R10 byte stored", 8'h11);
    reg_read(5, d); act_q.push_back(d[7:0]);
    m_start();
    wr_byte(8'h74, ack); chk("R10 ack again addr", ack, 1);
    wr_byte(8'h22, ack); chk("R10 ack again data", ack, 1);
    m_stop();
    reg_write(3, 16'h0007);

    // R5 R6 10-bit addressing
    reg_write(0, 16'h0001);
    reg_write(1, 16'h0200);
    reg_write(2, 16'h006D);
    reg_write(4, 16'h00C3);
    m_start();
    wr_byte(8'hF4, ack); chk("R5 header ack", ack, 1);
    wr_byte(8'h6D, ack); chk("R5 low byte ack", ack, 1);
    wr_byte(8'h33, ack); chk("R7 long data ack", ack, 1);
    m_start();
    wr_byte(8'hF5, ack); chk("R6 restart read ack", ack, 1);
    expect_byte("R6 long read byte", 8'hC3);
    rd_byte(b, 1'b0); act_q.push_back(b);
    m_stop();
    expect_byte("R7 long rxdata", 8'h33);
    reg_read(5, d); act_q.push_back(d[7:0]);
    m_start();
    wr_byte(8'hF4, ack); chk("R5 header ack 2", ack, 1);
    wr_byte(8'h6E, ack); chk("R5 wrong low nack", ack, 0);
    m_stop();
    m_start();
    wr_byte(8'hF5, ack); chk("R6 read without match nack", ack, 0);
    m_stop();
    reg_write(0, 16'h0000);
    reg_write(3, 16'h0007);

    // R11 stretch while SCL low
    m_start();
    reg_write(0, 16'h0040);
    repeat (3) @(negedge clk);
    chk("R11 scl_oe on", scl_oe, 1);
    m_scl = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 scl held", scl_line, 0);
    reg_write(0, 16'h0000);
    repeat (8) @(negedge clk);
    chk("R11 scl released", scl_line, 1);
    m_stop();

    // R12 stretch while SCL high
    reg_write(0, 16'h0040);
    repeat (20) @(negedge clk);
    chk("R12 no hold while high", scl_oe, 0);
    m_scl = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 hold after fall", scl_oe, 1);
    m_scl = 1'b1;
    repeat (10) @(negedge clk);
    chk("R12 scl kept low", scl_line, 0);
    reg_write(0, 16'h0000);
    repeat (8) @(negedge clk);
    chk("R12 scl released", scl_line, 1);

    repeat (20) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule